// File: doc/BRIEF.md
# MMU Fault Exception Entry Sequencer

This block carries out the hardware half of taking a translation protection fault. The lookup logic raises a one-cycle fault pulse. With it come the faulting virtual address, whether the access was a load or a store, the way that hit, the current program counter, the address of the enclosing delayed branch, a delay-slot flag, the current status word and the vector base. On the clock edge that samples the pulse, the sequencer fills every fault-capture register at once. It records the page number and the full address, an event code, the return address, the old status word and the faulting way. It also forms the new status word, with privileged mode, exception blocking and the alternate register bank all set.

One cycle later the sequencer raises a redirect strobe for exactly one cycle. The strobe carries the handler fetch address, which is the vector base plus 0x100. If the status word already has the blocking bit set when the fault arrives, the pulse is dropped. In that case no register changes and no redirect is issued. All captured values are exported so that the surrounding core can copy them into its architectural registers.

Top module: `fault_entry_seq`

## Requirements
- R1: While reset is held, and after it is released until the first accepted fault, every captured output reads zero and the redirect strobe is low.
- R2: On an accepted fault, faultAddrOut takes the full faulting virtual address.
- R3: On an accepted fault, pageNumOut takes the page number, which is address bits 31 down to 10 (22 bits).
- R4: On an accepted fault, eventCode becomes 0x0A0 for a load (faultIsStore = 0) and 0x0C0 for a store (faultIsStore = 1).
- R5: On an accepted fault, savedPc takes curPc when inDelaySlot is 0 and branchPc when inDelaySlot is 1.
- R6: On an accepted fault, savedSr takes srCur exactly as it was before any bit is modified.
- R7: On an accepted fault, srOut becomes srCur with bit 30 (privileged mode), bit 29 (register bank) and bit 28 (exception block) set to 1 and all other bits unchanged.
- R8: On an accepted fault, wayOut takes faultWay.
- R9: On an accepted fault, redirectAddr becomes vbr + 0x100, with the sum wrapping modulo 2^32.
- R10: redirectValid is 1 in exactly the cycle after the edge that accepts a fault, and is 0 otherwise.
- R11: A fault pulse that arrives while srCur bit 28 is 1 is ignored: all outputs keep their values and redirectValid stays 0.
- R12: In a cycle with no fault pulse, all captured outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultValid | input | 1 | One-cycle protection fault pulse |
| faultAddr | input | 32 | Faulting virtual address |
| faultIsStore | input | 1 | 1 = store access, 0 = load access |
| faultWay | input | 2 | Way index of the matching entry |
| curPc | input | 32 | Address of the faulting instruction |
| branchPc | input | 32 | Address of the delayed branch owning the slot |
| inDelaySlot | input | 1 | Fault instruction sits in a delay slot |
| srCur | input | 32 | Current status word |
| vbr | input | 32 | Vector base address |
| pageNumOut | output | 22 | Captured page number |
| faultAddrOut | output | 32 | Captured faulting address |
| eventCode | output | 12 | Captured exception event code |
| savedPc | output | 32 | Captured return address |
| savedSr | output | 32 | Status word saved at fault time |
| srOut | output | 32 | Modified status word |
| wayOut | output | 2 | Captured faulting way |
| redirectValid | output | 1 | One-cycle handler redirect strobe |
| redirectAddr | output | 32 | Handler fetch address |

## Verification
A vector table drives faults that mix loads and stores and delay-slot and ordinary positions. Status words in the table set various bits, so that preserved bits can be told apart from forced ones. Addresses sit at page edges and all-ones, and the vector base values include ones whose handler sum wraps. These show whether the event code follows the access type, whether the return address follows the slot flag, and whether the page number is cut at the right bit. Directed cases then check that a fault is dropped while the blocking bit is set, that back-to-back faults keep the later one, and that reset mid-run clears every output.

// File: rtl/fault_entry_pkg.sv
package fault_entry_pkg;
  localparam int EVT_W = 12;
  localparam logic [EVT_W-1:0] EVT_LOAD_FAULT  = 12'h0A0;
  localparam logic [EVT_W-1:0] EVT_STORE_FAULT = 12'h0C0;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // load every fault register this edge
    logic isStore;    // select store event code
    logic useBranch;  // return address is the delayed branch
  } seqStrobe_t;
endpackage

// File: rtl/fault_entry_ctrl.sv
module fault_entry_ctrl
  import fault_entry_pkg::*;
#(
  parameter int SR_W   = 32,
  parameter int BL_POS = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             faultValid,
  input  logic             faultIsStore,
  input  logic             inDelaySlot,
  input  logic [SR_W-1:0]  srCur,
  output seqStrobe_t       strobe,
  output logic             redirectValid
);
  logic accept;

  // A fault is taken only while exceptions are not blocked
  assign accept = faultValid && !srCur[BL_POS];

  always_comb begin
    strobe.capture   = accept;
    strobe.isStore   = faultIsStore;
    strobe.useBranch = inDelaySlot;
  end

  // Redirect goes out one cycle after the capture edge
  always_ff @(posedge clk) begin
    if (!rstN) redirectValid <= 1'b0;
    else       redirectValid <= accept;
  end
endmodule

// File: rtl/fault_entry_datapath.sv
module fault_entry_datapath
  import fault_entry_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int WAY_W      = 2,
  parameter int SR_W       = 32,
  parameter int MD_POS     = 30,
  parameter int RB_POS     = 29,
  parameter int BL_POS     = 28,
  parameter logic [ADDR_W-1:0] VEC_OFFSET = 'h100,
  localparam int VPN_W = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic [WAY_W-1:0]  faultWay,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] branchPc,
  input  logic [SR_W-1:0]   srCur,
  input  logic [ADDR_W-1:0] vbr,
  output logic [VPN_W-1:0]  pageNumOut,
  output logic [ADDR_W-1:0] faultAddrOut,
  output logic [EVT_W-1:0]  eventCode,
  output logic [ADDR_W-1:0] savedPc,
  output logic [SR_W-1:0]   savedSr,
  output logic [SR_W-1:0]   srOut,
  output logic [WAY_W-1:0]  wayOut,
  output logic [ADDR_W-1:0] redirectAddr
);
  localparam logic [SR_W-1:0] SR_FORCE =
    (SR_W'(1) << MD_POS) | (SR_W'(1) << RB_POS) | (SR_W'(1) << BL_POS);

  logic [ADDR_W-1:0] retAddr;
  logic [EVT_W-1:0]  evtNext;

  assign retAddr = strobe.useBranch ? branchPc : curPc;
  assign evtNext = strobe.isStore ? EVT_STORE_FAULT : EVT_LOAD_FAULT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageNumOut   <= '0;
      faultAddrOut <= '0;
      eventCode    <= '0;
      savedPc      <= '0;
      savedSr      <= '0;
      srOut        <= '0;
      wayOut       <= '0;
      redirectAddr <= '0;
    end else if (strobe.capture) begin
      pageNumOut   <= faultAddr[ADDR_W-1:PAGE_SHIFT];
      faultAddrOut <= faultAddr;
      eventCode    <= evtNext;
      savedPc      <= retAddr;
      savedSr      <= srCur;             // old value, before forcing bits
      srOut        <= srCur | SR_FORCE;
      wayOut       <= faultWay;
      redirectAddr <= vbr + VEC_OFFSET;
    end
  end
endmodule

// File: rtl/fault_entry_seq.sv
module fault_entry_seq
  import fault_entry_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int WAY_W      = 2,
  parameter int SR_W       = 32,
  parameter int MD_POS     = 30,
  parameter int RB_POS     = 29,
  parameter int BL_POS     = 28,
  parameter logic [ADDR_W-1:0] VEC_OFFSET = 'h100,
  localparam int VPN_W = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultValid,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              faultIsStore,
  input  logic [WAY_W-1:0]  faultWay,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] branchPc,
  input  logic              inDelaySlot,
  input  logic [SR_W-1:0]   srCur,
  input  logic [ADDR_W-1:0] vbr,
  output logic [VPN_W-1:0]  pageNumOut,
  output logic [ADDR_W-1:0] faultAddrOut,
  output logic [EVT_W-1:0]  eventCode,
  output logic [ADDR_W-1:0] savedPc,
  output logic [SR_W-1:0]   savedSr,
  output logic [SR_W-1:0]   srOut,
  output logic [WAY_W-1:0]  wayOut,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectAddr
);
  seqStrobe_t strobe;

  fault_entry_ctrl #(.SR_W(SR_W), .BL_POS(BL_POS)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .faultValid    (faultValid),
    .faultIsStore  (faultIsStore),
    .inDelaySlot   (inDelaySlot),
    .srCur         (srCur),
    .strobe        (strobe),
    .redirectValid (redirectValid)
  );

  fault_entry_datapath #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .WAY_W(WAY_W), .SR_W(SR_W),
    .MD_POS(MD_POS), .RB_POS(RB_POS), .BL_POS(BL_POS), .VEC_OFFSET(VEC_OFFSET)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .faultAddr    (faultAddr),
    .faultWay     (faultWay),
    .curPc        (curPc),
    .branchPc     (branchPc),
    .srCur        (srCur),
    .vbr          (vbr),
    .pageNumOut   (pageNumOut),
    .faultAddrOut (faultAddrOut),
    .eventCode    (eventCode),
    .savedPc      (savedPc),
    .savedSr      (savedSr),
    .srOut        (srOut),
    .wayOut       (wayOut),
    .redirectAddr (redirectAddr)
  );
endmodule

// File: rtl/fault_entry_chk.sv
module fault_entry_chk
  import fault_entry_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int WAY_W      = 2,
  parameter int SR_W       = 32,
  parameter int MD_POS     = 30,
  parameter int RB_POS     = 29,
  parameter int BL_POS     = 28,
  parameter logic [ADDR_W-1:0] VEC_OFFSET = 'h100,
  localparam int VPN_W = ADDR_W - PAGE_SHIFT
) (
  input logic              clk,
  input logic              rstN,
  input logic              faultValid,
  input logic [ADDR_W-1:0] faultAddr,
  input logic              faultIsStore,
  input logic [WAY_W-1:0]  faultWay,
  input logic [ADDR_W-1:0] curPc,
  input logic [ADDR_W-1:0] branchPc,
  input logic              inDelaySlot,
  input logic [SR_W-1:0]   srCur,
  input logic [ADDR_W-1:0] vbr,
  input logic [VPN_W-1:0]  pageNumOut,
  input logic [ADDR_W-1:0] faultAddrOut,
  input logic [EVT_W-1:0]  eventCode,
  input logic [ADDR_W-1:0] savedPc,
  input logic [SR_W-1:0]   savedSr,
  input logic [SR_W-1:0]   srOut,
  input logic [WAY_W-1:0]  wayOut,
  input logic              redirectValid,
  input logic [ADDR_W-1:0] redirectAddr
);
  logic taken;
  logic blocked;
  assign taken   = faultValid && !srCur[BL_POS];
  assign blocked = faultValid && srCur[BL_POS];

  p_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    taken |=> faultAddrOut == $past(faultAddr));
  p_page_r3: assert property (@(posedge clk) disable iff (!rstN)
    taken |=> pageNumOut == $past(faultAddr[ADDR_W-1:PAGE_SHIFT]));
  p_event_r4: assert property (@(posedge clk) disable iff (!rstN)
    taken |=> eventCode == ($past(faultIsStore) ? 12'h0C0 : 12'h0A0));
  p_retpc_r5: assert property (@(posedge clk) disable iff (!rstN)
    taken |=> savedPc == ($past(inDelaySlot) ? $past(branchPc) : $past(curPc)));
  p_oldsr_r6: assert property (@(posedge clk) disable iff (!rstN)
    taken |=> savedSr == $past(srCur));
  p_newsr_r7: assert property (@(posedge clk) disable iff (!rstN)
    taken |=> srOut[MD_POS] && srOut[RB_POS] && srOut[BL_POS] && savedSr[0] == srOut[0]);
  p_way_r8: assert property (@(posedge clk) disable iff (!rstN)
    taken |=> wayOut == $past(faultWay));
  p_vector_r9: assert property (@(posedge clk) disable iff (!rstN)
    taken |=> redirectAddr == $past(vbr) + VEC_OFFSET);
  p_strobe_on_r10: assert property (@(posedge clk) disable iff (!rstN)
    taken |=> redirectValid);
  p_strobe_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !taken |=> !redirectValid);
  p_ignore_r11: assert property (@(posedge clk) disable iff (!rstN)
    blocked |=> $stable(faultAddrOut) && $stable(savedSr) && $stable(srOut));
  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |=> $stable(savedPc) && $stable(eventCode) && $stable(redirectAddr));
endmodule

bind fault_entry_seq fault_entry_chk #(
  .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .WAY_W(WAY_W), .SR_W(SR_W),
  .MD_POS(MD_POS), .RB_POS(RB_POS), .BL_POS(BL_POS), .VEC_OFFSET(VEC_OFFSET)
) u_chk (.*);

// File: tb/tb_fault_entry_seq.sv
module tb_fault_entry_seq;
  typedef struct packed {
    logic [31:0] addr;
    logic        isStore;
    logic [31:0] pc;
    logic [31:0] br;
    logic        ds;
    logic [31:0] sr;
    logic [31:0] vb;
    logic [1:0]  way;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1234_5678, 1'b0, 32'h8000_1000, 32'h8000_0FFE, 1'b0, 32'h0000_00F0, 32'h8000_0000, 2'd0},
    '{32'hABCD_EC00, 1'b1, 32'h8C00_2000, 32'h8C00_1FFE, 1'b1, 32'h4000_0001, 32'h8C00_0000, 2'd3},
    '{32'h0000_03FF, 1'b0, 32'h0000_0010, 32'h0000_000E, 1'b1, 32'h0FFF_FFFF, 32'h0000_0000, 2'd1},
    '{32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFE, 32'h0000_0000, 1'b0, 32'h8000_0000, 32'hFFFF_FF00, 2'd2},
    '{32'h7FFF_FC00, 1'b1, 32'h0000_4000, 32'h0000_3FFE, 1'b0, 32'h6FFF_FFFF, 32'h0000_0F00, 2'd1},
    '{32'h8000_0400, 1'b0, 32'h0000_0002, 32'h0000_0000, 1'b1, 32'h0000_0000, 32'hFFFF_FF80, 2'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic faultValid = 1'b0;
  logic [31:0] faultAddr = '0;
  logic faultIsStore = 1'b0;
  logic [1:0] faultWay = '0;
  logic [31:0] curPc = '0, branchPc = '0, srCur = '0, vbr = '0;
  logic inDelaySlot = 1'b0;
  logic [21:0] pageNumOut;
  logic [31:0] faultAddrOut, savedPc, savedSr, srOut, redirectAddr;
  logic [11:0] eventCode;
  logic [1:0] wayOut;
  logic redirectValid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fault_entry_seq dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic pulse);
    faultAddr = v.addr; faultIsStore = v.isStore; curPc = v.pc; branchPc = v.br;
    inDelaySlot = v.ds; srCur = v.sr; vbr = v.vb; faultWay = v.way; faultValid = pulse;
  endtask

  task automatic expectAll(input vec_t v);
    chk("R2 faultAddrOut", faultAddrOut, v.addr);
    chk("R3 pageNumOut", {10'b0, pageNumOut}, {10'b0, v.addr[31:10]});
    chk("R4 eventCode", {20'b0, eventCode}, v.isStore ? 32'h0C0 : 32'h0A0);
    chk("R5 savedPc", savedPc, v.ds ? v.br : v.pc);
    chk("R6 savedSr", savedSr, v.sr);
    chk("R7 srOut", srOut, v.sr | 32'h7000_0000);
    chk("R8 wayOut", {30'b0, wayOut}, {30'b0, v.way});
    chk("R9 redirectAddr", redirectAddr, v.vb + 32'h100);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    vec_t blk;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 redirectValid in reset", {31'b0, redirectValid}, 0);
    chk("R1 srOut in reset", srOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 faultAddrOut after reset", faultAddrOut, 0);
    chk("R1 redirectAddr after reset", redirectAddr, 0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i], 1'b1);
      @(negedge clk);
      chk("R10 strobe cycle after capture", {31'b0, redirectValid}, 1);
      expectAll(VECS[i]);
      faultValid = 1'b0;
      faultAddr = ~faultAddr; curPc = ~curPc; vbr = ~vbr; srCur = ~srCur;
      @(negedge clk);
      chk("R10 strobe drops after one cycle", {31'b0, redirectValid}, 0);
      expectAll(VECS[i]);  // R12 hold with changed inputs, no pulse
    end

    // R11: pulse while blocking bit set
    blk = '{32'hDEAD_BEEF, 1'b1, 32'h1111_1110, 32'h2222_2220, 1'b1, 32'h1000_0000, 32'h3333_0000, 2'd3};
    drive(blk, 1'b1);
    @(negedge clk);
    chk("R11 no strobe when blocked", {31'b0, redirectValid}, 0);
    expectAll(VECS[NVEC-1]);
    faultValid = 1'b0;
    @(negedge clk);
    chk("R11 still no strobe", {31'b0, redirectValid}, 0);

    // Back-to-back accepted faults: later one wins, strobe stays up
    drive(VECS[0], 1'b1);
    @(negedge clk);
    drive(VECS[1], 1'b1);
    @(negedge clk);
    chk("R10 strobe back-to-back", {31'b0, redirectValid}, 1);
    expectAll(VECS[1]);
    faultValid = 1'b0;
    @(negedge clk);
    chk("R10 strobe ends after burst", {31'b0, redirectValid}, 0);

    // R1: reset mid-run clears state
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 savedPc cleared", savedPc, 0);
    chk("R1 eventCode cleared", {20'b0, eventCode}, 0);
    rstN = 1'b1;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule